// File: doc/BRIEF.md
# Serial control port register file with buffered update

This block is the control port of a frequency synthesizer as seen from a host microcontroller. It is an SPI slave in clock mode 0. Frames are 8 bits, most significant bit first. Each transaction starts with one instruction byte. Bit 7 of that byte selects read (1) or write (0), and bits 4:0 name a register. A fixed number of data bytes then follows, most significant byte first. That count depends only on the register number.

Writes land in a shadow bank. A separate update input copies the whole shadow bank into the active bank in one cycle. The active bank drives the synthesizer datapath through a parallel output bus. Reads return the shadow contents, so the host can verify what it wrote before it commits.

All pins are sampled in the system clock domain through synchronizers. The SPI clock must therefore be well below the system clock: each SCLK level must last at least eight system clocks.

Top module: `spi_regs`

## Requirements
- R1: While reset is held, and after it is released, every active slot reads zero and MISO is low. Both banks are cleared, so reading any register after reset returns zero bytes.
- R2: A high level on `update` copies every shadow register into its active slot. Register i occupies bits [40*i+39 : 40*i] of `active_o` and is zero-extended above its own width.
- R3: A write changes only the shadow register. The active slot holds its old value until the next update.
- R4: Each register takes a fixed number of data bytes, sent most significant first. Registers 0, 4 and 6 take 4 bytes. Register 1 takes 3. Registers 2 and 5 take 2. Register 3 takes 1. Registers 7 and 8 take 5. Any further bytes in the same chip-select window are ignored.
- R5: For a read (instruction bit 7 set), the slave shifts out the addressed shadow register over that register's byte count, most significant bit first. MISO changes after the falling SCLK edge, so the master can sample it on the rising edge.
- R6: Raising chip select mid-transfer discards a partial write. This holds whether the break comes inside a byte or between bytes. The next transaction is decoded from its instruction byte.
- R7: Registers 9 to 31 take a single data byte. Writes to them change nothing, and reads of them return 0x00.
- R8: The update input acts only on its rising edge. Holding it high makes exactly one copy, and writes made while it stays high do not reach the active bank.
- R9: MISO is driven low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sclk | input | 1 | SPI serial clock, idles low |
| cs_n | input | 1 | Active-low chip select framing one transaction |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master, low when deselected |
| update | input | 1 | Commit strobe, acts on its rising edge |
| active_o | output | 360 | Active bank, nine 40-bit slots, register i at bits 40*i+39 : 40*i |

## Verification
The bench builds the block with its default two-stage synchronizers. It runs SCLK at sixteen system clocks per bit, which leaves margin for the synchronizer and MISO register delays. With that setting it covers every register length from one to five bytes, including trailing surplus bytes. It also covers aborts inside a byte and between bytes, and reads of out-of-range registers. Finally, it holds the update level high across a write and asserts reset mid-run to show that both banks clear.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;

  localparam int NUM_REGS  = 9;
  localparam int MAX_BYTES = 5;
  localparam int ADDR_W    = 5;
  localparam int REG_BITS  = MAX_BYTES * 8;
  localparam int ACT_W     = NUM_REGS * REG_BITS;
  localparam int LEN_W     = $clog2(MAX_BYTES + 1);

  typedef enum logic [1:0] {
    ST_INSTR = 2'd0,
    ST_DATA  = 2'd1,
    ST_DONE  = 2'd2
  } port_state_t;

  // Data byte count per register number; unknown registers take one byte.
  function automatic logic [LEN_W-1:0] reg_len(input logic [ADDR_W-1:0] a);
    case (a)
      5'd0, 5'd4, 5'd6: reg_len = LEN_W'(4);
      5'd1:             reg_len = LEN_W'(3);
      5'd2, 5'd5:       reg_len = LEN_W'(2);
      5'd3:             reg_len = LEN_W'(1);
      5'd7, 5'd8:       reg_len = LEN_W'(5);
      default:          reg_len = LEN_W'(1);
    endcase
  endfunction

endpackage

// File: rtl/spi_regs_sync.sv
module spi_regs_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] pipe_q;
  logic [STAGES-1:0][WIDTH-1:0] pipe_n;

  always_comb begin
    pipe_n[0] = d;
    for (int s = 1; s < STAGES; s++) pipe_n[s] = pipe_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
    else        pipe_q <= pipe_n;
  end

  assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/spi_regs_shifter.sv
module spi_regs_shifter
  import spi_regs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk_s,
  input  logic                cs_n_s,
  input  logic                mosi_s,
  input  logic                tx_load,
  input  logic [REG_BITS-1:0] tx_word,
  output logic                byte_vld,
  output logic [7:0]          byte_data,
  output logic                miso
);

  logic                sclk_q;
  logic [2:0]          bit_q,  bit_n;
  logic [6:0]          rx_q,   rx_n;
  logic [REG_BITS-1:0] tx_q,   tx_n;
  logic                miso_q, miso_n;
  logic                rise, fall;

  assign rise = sclk_s & ~sclk_q;
  assign fall = ~sclk_s & sclk_q;

  assign byte_vld  = rise && !cs_n_s && (bit_q == 3'd7);
  assign byte_data = {rx_q, mosi_s};

  always_comb begin
    bit_n  = bit_q;
    rx_n   = rx_q;
    tx_n   = tx_q;
    miso_n = miso_q;
    if (cs_n_s) begin
      bit_n  = '0;
      tx_n   = '0;
      miso_n = 1'b0;
    end else begin
      if (rise) begin
        rx_n  = {rx_q[5:0], mosi_s};
        bit_n = bit_q + 3'd1;
      end
      if (tx_load) begin
        tx_n = tx_word;
      end else if (fall) begin
        miso_n = tx_q[REG_BITS-1];
        tx_n   = {tx_q[REG_BITS-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      bit_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      miso_q <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      bit_q  <= bit_n;
      rx_q   <= rx_n;
      tx_q   <= tx_n;
      miso_q <= miso_n;
    end
  end

  assign miso = miso_q;

endmodule

// File: rtl/spi_regs_core.sv
module spi_regs_core
  import spi_regs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n_s,
  input  logic                byte_vld,
  input  logic [7:0]          byte_data,
  input  logic                upd_edge,
  output logic                tx_load,
  output logic [REG_BITS-1:0] tx_word,
  output logic [ACT_W-1:0]    shadow_flat,
  output logic [ACT_W-1:0]    active_flat
);

  port_state_t         state_q, state_n;
  logic [ADDR_W-1:0]   addr_q,  addr_n;
  logic                rd_q,    rd_n;
  logic [LEN_W-1:0]    left_q,  left_n;
  logic [REG_BITS-1:0] stage_q, stage_n;
  logic [REG_BITS-1:0] data_word;
  logic                commit;

  logic [NUM_REGS-1:0][REG_BITS-1:0] shadow_q, shadow_n;
  logic [NUM_REGS-1:0][REG_BITS-1:0] active_q, active_n;

  logic [ADDR_W-1:0]   instr_addr;
  logic [REG_BITS-1:0] rd_sel;
  logic [5:0]          rd_shift;
  logic [1:0]          unused_bits;

  assign instr_addr  = byte_data[ADDR_W-1:0];
  assign unused_bits = byte_data[6:5];
  assign data_word   = {stage_q[REG_BITS-9:0], byte_data};

  // Transaction decoder: next state
  always_comb begin
    state_n = state_q;
    addr_n  = addr_q;
    rd_n    = rd_q;
    left_n  = left_q;
    stage_n = stage_q;
    commit  = 1'b0;
    if (cs_n_s) begin
      state_n = ST_INSTR;
      left_n  = '0;
      stage_n = '0;
    end else if (byte_vld) begin
      unique case (state_q)
        ST_INSTR: begin
          addr_n  = instr_addr;
          rd_n    = byte_data[7];
          left_n  = reg_len(instr_addr);
          stage_n = '0;
          state_n = ST_DATA;
        end
        ST_DATA: begin
          stage_n = data_word;
          left_n  = left_q - LEN_W'(1);
          if (left_q == LEN_W'(1)) begin
            state_n = ST_DONE;
            commit  = !rd_q && (addr_q < ADDR_W'(NUM_REGS));
          end
        end
        default: ;
      endcase
    end
  end

  // Register banks: next state
  always_comb begin
    shadow_n = shadow_q;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (commit && (addr_q == ADDR_W'(i))) shadow_n[i] = data_word;
    end
    active_n = upd_edge ? shadow_q : active_q;
  end

  // Read path: left-align the addressed shadow register
  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (instr_addr == ADDR_W'(i)) rd_sel = shadow_q[i];
    end
    rd_shift = 6'(8 * (MAX_BYTES - int'(reg_len(instr_addr))));
    tx_word  = rd_sel << rd_shift;
    tx_load  = byte_vld && !cs_n_s && (state_q == ST_INSTR) && byte_data[7];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_INSTR;
      addr_q   <= '0;
      rd_q     <= 1'b0;
      left_q   <= '0;
      stage_q  <= '0;
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      state_q  <= state_n;
      addr_q   <= addr_n;
      rd_q     <= rd_n;
      left_q   <= left_n;
      stage_q  <= stage_n;
      shadow_q <= shadow_n;
      active_q <= active_n;
    end
  end

  assign shadow_flat = shadow_q;
  assign active_flat = active_q;

endmodule

// File: rtl/spi_regs.sv
module spi_regs
  import spi_regs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             mosi,
  output logic             miso,
  input  logic             update,
  output logic [ACT_W-1:0] active_o
);

  logic [1:0]          rst_pipe;
  logic                rst_sn;
  logic                sclk_s, cs_n_s, mosi_s;
  logic                upd_s, upd_q, upd_edge;
  logic                byte_vld;
  logic [7:0]          byte_data;
  logic                tx_load;
  logic [REG_BITS-1:0] tx_word;
  logic [ACT_W-1:0]    shadow_flat;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  spi_regs_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_sn),
    .d     ({sclk, cs_n, mosi}),
    .q     ({sclk_s, cs_n_s, mosi_s})
  );

  spi_regs_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_upd_sync (
    .clk   (clk),
    .rst_n (rst_sn),
    .d     (update),
    .q     (upd_s)
  );

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) upd_q <= 1'b0;
    else         upd_q <= upd_s;
  end
  assign upd_edge = upd_s & ~upd_q;

  spi_regs_shifter u_shifter (
    .clk       (clk),
    .rst_n     (rst_sn),
    .sclk_s    (sclk_s),
    .cs_n_s    (cs_n_s),
    .mosi_s    (mosi_s),
    .tx_load   (tx_load),
    .tx_word   (tx_word),
    .byte_vld  (byte_vld),
    .byte_data (byte_data),
    .miso      (miso)
  );

  spi_regs_core u_core (
    .clk         (clk),
    .rst_n       (rst_sn),
    .cs_n_s      (cs_n_s),
    .byte_vld    (byte_vld),
    .byte_data   (byte_data),
    .upd_edge    (upd_edge),
    .tx_load     (tx_load),
    .tx_word     (tx_word),
    .shadow_flat (shadow_flat),
    .active_flat (active_o)
  );

endmodule

// File: rtl/spi_regs_chk.sv
module spi_regs_chk
  import spi_regs_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             rst_sn,
  input logic             cs_n_s,
  input logic             miso,
  input logic             upd_edge,
  input logic [ACT_W-1:0] active_o,
  input logic [ACT_W-1:0] shadow_flat
);

  // R1: the active bank stays cleared while reset is held
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst_n)
    !rst_sn |=> (active_o == '0) && !miso);

  // R3: without an update edge the active bank does not move
  assert_active_hold_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    !upd_edge |=> $stable(active_o));

  // R6: nothing is committed to the shadow bank while deselected
  assert_shadow_idle_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    cs_n_s |=> $stable(shadow_flat));

  // R9: MISO low while chip select is high
  assert_miso_idle_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    (cs_n_s && $past(cs_n_s)) |-> !miso);

  // R8: an update edge is a single-cycle event
  assert_single_copy_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    upd_edge |=> !upd_edge);

endmodule

bind spi_regs spi_regs_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rst_sn      (rst_sn),
  .cs_n_s      (cs_n_s),
  .miso        (miso),
  .upd_edge    (upd_edge),
  .active_o    (active_o),
  .shadow_flat (shadow_flat)
);

// File: tb/spi_regs_tb.sv
module spi_regs_tb;
  import spi_regs_pkg::*;

  localparam int HALF = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, sclk, cs_n, mosi, update;
  logic miso;
  logic [ACT_W-1:0] active_o;

  spi_regs u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .update(update), .active_o(active_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [39:0] sh_m [9];
  logic [39:0] ac_m [9];
  logic [7:0]  exp_q [$];
  string       tag_q [$];
  logic        rd_mon = 1'b0;

  function automatic int len_of(int a);
    case (a)
      0, 4, 6: return 4;
      1:       return 3;
      2, 5:    return 2;
      3:       return 1;
      7, 8:    return 5;
      default: return 1;
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(logic [7:0] b, int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = b[i];
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic cs_open();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_close();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic spi_write(int a, logic [39:0] v, int extra);
    int n = len_of(a);
    logic [63:0] mask = (64'd1 << (8 * n)) - 64'd1;
    cs_open();
    send_bits(8'(a), 8);
    for (int k = n - 1; k >= 0; k--) send_bits(v[8*k +: 8], 8);
    for (int k = 0; k < extra; k++) send_bits(8'hEE, 8);
    cs_close();
    if (a < 9) sh_m[a] = v & mask[39:0];
  endtask

  // Driver side of the scoreboard: push the bytes the read must return
  task automatic spi_read(int a, string tag);
    int n = len_of(a);
    logic [39:0] v = (a < 9) ? sh_m[a] : 40'd0;
    cs_open();
    send_bits(8'h80 | 8'(a), 8);
    for (int k = n - 1; k >= 0; k--) begin
      exp_q.push_back(v[8*k +: 8]);
      tag_q.push_back(tag);
    end
    rd_mon = 1'b1;
    for (int k = 0; k < n; k++) send_bits(8'h00, 8);
    rd_mon = 1'b0;
    cs_close();
    chk("R9 miso low after deselect", 64'(miso), 64'd0);
  endtask

  task automatic pulse_update();
    update = 1'b1;
    wait_clk(5 * 2 * HALF);
    update = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < 9; i++) ac_m[i] = sh_m[i];
  endtask

  task automatic check_active(string tag);
    for (int i = 0; i < 9; i++) chk(tag, 64'(active_o[i*40 +: 40]), 64'(ac_m[i]));
  endtask

  // Monitor side of the scoreboard: assemble MISO bytes on rising SCLK
  initial begin : monitor
    logic [7:0] sh = '0;
    int nb = 0;
    forever begin
      @(posedge sclk);
      if (rd_mon) begin
        sh = {sh[6:0], miso};
        nb++;
        if (nb == 8) begin
          nb = 0;
          if (exp_q.size() == 0) chk("R5 unexpected read byte", 64'(sh), 64'hFFFF);
          else chk(tag_q.pop_front(), 64'(sh), 64'(exp_q.pop_front()));
        end
      end
    end
  end

  initial begin : watchdog
    wait_clk(150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired, actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0; update = 1'b0;
    for (int i = 0; i < 9; i++) begin sh_m[i] = '0; ac_m[i] = '0; end
    wait_clk(6);
    check_active("R1 active zero in reset");
    chk("R1 miso low in reset", 64'(miso), 64'd0);
    rst_n = 1'b1;
    wait_clk(6);
    chk("R9 miso idle", 64'(miso), 64'd0);

    // R3 then R5 then R2
    spi_write(0, 40'h00A1B2C3D4, 0);
    check_active("R3 active unchanged after write");
    spi_read(0, "R5 read shadow reg0");
    pulse_update();
    check_active("R2 copy after update");

    // R4: every register length, with surplus bytes after the last one
    for (int a = 0; a < 9; a++) spi_write(a, 40'h1122334455 + 40'(a * 40'h0101010101), (a % 2));
    check_active("R3 active unchanged after batch");
    for (int a = 0; a < 9; a++) spi_read(a, "R4 read length and order");
    pulse_update();
    check_active("R4 active after batch update");

    // R6: abort between bytes and inside a byte
    cs_open(); send_bits(8'h02, 8); send_bits(8'h55, 8); cs_close();
    cs_open(); send_bits(8'h05, 8); send_bits(8'h9A, 8); send_bits(8'hBC, 4); cs_close();
    cs_open(); send_bits(8'h03, 5); cs_close();
    pulse_update();
    check_active("R6 partial writes discarded");
    spi_write(2, 40'h000000BEEF, 0);
    spi_read(2, "R6 decode resumes after abort");
    pulse_update();
    check_active("R6 write after abort");

    // R7: out-of-range registers
    spi_write(12, 40'h00000000FF, 0);
    spi_write(31, 40'h0000000077, 0);
    spi_read(12, "R7 read out of range");
    spi_read(9, "R7 read reg9");
    pulse_update();
    check_active("R7 out of range write ignored");

    // R8: held update makes one copy only
    spi_write(3, 40'h11, 0);
    update = 1'b1;
    wait_clk(HALF);
    for (int i = 0; i < 9; i++) ac_m[i] = sh_m[i];
    check_active("R8 copy on rising edge");
    spi_write(3, 40'h77, 0);
    wait_clk(HALF);
    check_active("R8 held high no second copy");
    update = 1'b0;
    wait_clk(HALF);
    check_active("R8 falling edge no copy");
    pulse_update();
    check_active("R8 next rising edge copies");

    // R1: reset mid-run clears both banks
    rst_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < 9; i++) begin sh_m[i] = '0; ac_m[i] = '0; end
    check_active("R1 reset clears active");
    rst_n = 1'b1;
    wait_clk(6);
    spi_read(7, "R1 shadow cleared by reset");
    pulse_update();
    check_active("R1 active still zero");

    wait_clk(4);
    chk("R5 scoreboard drained", 64'(exp_q.size()), 64'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule